// File: doc/BRIEF.md
# Thermal Alarm Output Controller

This block turns a stream of 9-bit two's-complement temperature samples into one alarm pin. Every accepted sample is compared with a high threshold and a low threshold. A debounce stage then requires a programmable number of consecutive samples in the same region before the alarm logic reacts. The alarm has two modes. As a thermostat comparator, it turns on above the high threshold and off below the low threshold. As a latched interrupt, it raises an event and holds it until the bus interface reports a register read.

The pin is driven open-drain, so the block outputs only a pull-down enable. The polarity setting decides whether the active state pulls the pin low or releases it. A shutdown bit stops the block from taking samples. Entering shutdown in interrupt mode drops any pending event. In comparator mode the state is kept through shutdown.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After reset (synchronous, active high), the alarm is inactive, so with cfg_reg = 0 the pin is not pulled low (od_pull_low = 0).
- R2: A sample is "hot" when, as a signed 9-bit value, it is strictly greater than thr_high. It is "cold" when it is strictly less than thr_low. A sample equal to a threshold is neither hot nor cold.
- R3: cfg_reg bits 4:3 set the debounce depth: 00 is 1, 01 is 2, 10 is 4 and 11 is 6 consecutive accepted samples of the same kind before the alarm logic sees an event.
- R4: An accepted sample of a different kind restarts the consecutive count, and a sample that is neither hot nor cold counts as a different kind.
- R5: While cfg_reg bit 0 (shutdown) is 1, samples are ignored. They neither add to a run nor break it.
- R6: With cfg_reg bit 1 = 0 (comparator mode), a hot event makes the alarm active and a cold event makes it inactive. Otherwise the alarm holds its state.
- R7: With cfg_reg bit 1 = 1 (interrupt mode), a hot event makes the alarm active until a reg_read pulse. After that, hot events are ignored and a cold event makes the alarm active until the next reg_read. After that second read, the block is armed for hot events again.
- R8: When shutdown goes from 0 to 1 in interrupt mode, the alarm goes inactive and arming advances as if a read had occurred. In comparator mode the alarm state is held through shutdown.
- R9: With cfg_reg bit 2 = 0 the pin is pulled low while the alarm is active. With bit 2 = 1 the pin is pulled low while the alarm is inactive.
- R10: reg_read has no effect in comparator mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_temp | input | 9 | Sample, two's complement, half-degree units |
| thr_high | input | 9 | High (setpoint) threshold, two's complement |
| thr_low | input | 9 | Low (hysteresis) threshold, two's complement |
| cfg_reg | input | 8 | bit0 shutdown, bit1 interrupt mode, bit2 active-high, bits4:3 depth, rest unused |
| reg_read | input | 1 | One-cycle pulse when the bus reads any register |
| od_pull_low | output | 1 | 1 = pull the open-drain alarm pin low |

## Verification
The comparator sweep feeds all 512 sample codes in a scrambled order against thresholds of opposite sign. This separates signed from unsigned comparison and strict from inclusive comparison. A second sweep tries every depth code with runs of one to seven hot samples, which pins down the depth encoding at both ends of each run. Directed patterns then cover these cases: a run broken by a middle sample; samples during shutdown; the four-phase interrupt cycle with mixed hot and cold samples; shutdown entry in both modes; reads in comparator mode; and both polarities.

// File: rtl/thal_pkg.sv
package thal_pkg;

    typedef struct packed {
        logic [2:0] unused;
        logic [1:0] depth_sel;
        logic       act_high;
        logic       irq_mode;
        logic       shutdown;
    } cfg_t;

    typedef struct packed {
        logic hot;
        logic cold;
    } cmp_t;

    typedef enum logic [1:0] {
        CLS_MID  = 2'd0,
        CLS_HOT  = 2'd1,
        CLS_COLD = 2'd2
    } cls_e;

    typedef enum logic [1:0] {
        IRQ_ARM_HOT   = 2'd0,
        IRQ_PEND_HOT  = 2'd1,
        IRQ_ARM_COLD  = 2'd2,
        IRQ_PEND_COLD = 2'd3
    } irq_e;

    localparam int DEPTH_W = 3;

    function automatic logic [DEPTH_W-1:0] depth_of(input logic [1:0] sel);
        case (sel)
            2'b00:   depth_of = 3'd1;
            2'b01:   depth_of = 3'd2;
            2'b10:   depth_of = 3'd4;
            default: depth_of = 3'd6;
        endcase
    endfunction

    function automatic cls_e classify(input cmp_t c);
        if (c.hot)       classify = CLS_HOT;
        else if (c.cold) classify = CLS_COLD;
        else             classify = CLS_MID;
    endfunction

endpackage

// File: rtl/thal_compare.sv
module thal_compare #(
    parameter int TEMP_W = 9
) (
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] hi_thr,
    input  logic [TEMP_W-1:0] lo_thr,
    output thal_pkg::cmp_t    res
);
    always_comb begin
        res.hot  = $signed(temp) > $signed(hi_thr);
        res.cold = $signed(temp) < $signed(lo_thr);
    end
endmodule

// File: rtl/thal_fault_queue.sv
module thal_fault_queue #(
    parameter int CNT_W = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  thal_pkg::cmp_t cmp,
    input  logic [1:0]     depth_sel,
    output logic           hot_evt,
    output logic           cold_evt
);
    import thal_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cls_e             run_cls;
    logic [CNT_W-1:0] run_cnt;
    cls_e             cls_now;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] depth;

    always_comb begin
        cls_now = classify(cmp);
        depth   = CNT_W'(depth_of(depth_sel));
        if (cls_now == run_cls)
            cnt_nxt = (run_cnt == CNT_MAX) ? run_cnt : run_cnt + 1'b1;
        else
            cnt_nxt = {{(CNT_W-1){1'b0}}, 1'b1};
        hot_evt  = accept && (cls_now == CLS_HOT)  && (cnt_nxt >= depth);
        cold_evt = accept && (cls_now == CLS_COLD) && (cnt_nxt >= depth);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cls <= CLS_MID;
            run_cnt <= '0;
        end else if (accept) begin
            run_cls <= cls_now;
            run_cnt <= cnt_nxt;
        end
    end

    // R5: events only come from accepted samples
    a_r5_evt_needs_accept: assert property (@(posedge clk) disable iff (rst)
        (hot_evt || cold_evt) |-> accept);

    // R2: a sample is never both kinds of event
    a_r2_evt_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hot_evt, cold_evt}));

    // R5: state frozen while no sample is accepted
    a_r5_run_frozen: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(run_cnt));
endmodule

// File: rtl/thal_alarm_out.sv
module thal_alarm_out (
    input  logic clk,
    input  logic rst,
    input  logic hot_evt,
    input  logic cold_evt,
    input  logic reg_read,
    input  logic irq_mode,
    input  logic act_high,
    input  logic shutdown,
    output logic od_pull_low
);
    import thal_pkg::*;

    logic shut_q;
    logic comp_q;
    irq_e irq_q;
    irq_e irq_nxt;
    logic shut_entry;
    logic irq_pending;
    logic active;

    always_comb begin
        shut_entry = shutdown && !shut_q;
        irq_nxt    = irq_q;
        if (!irq_mode) begin
            irq_nxt = IRQ_ARM_HOT;
        end else begin
            case (irq_q)
                IRQ_ARM_HOT:   if (hot_evt)               irq_nxt = IRQ_PEND_HOT;
                IRQ_PEND_HOT:  if (reg_read || shut_entry) irq_nxt = IRQ_ARM_COLD;
                IRQ_ARM_COLD:  if (cold_evt)              irq_nxt = IRQ_PEND_COLD;
                default:       if (reg_read || shut_entry) irq_nxt = IRQ_ARM_HOT;
            endcase
        end
        irq_pending = (irq_q == IRQ_PEND_HOT) || (irq_q == IRQ_PEND_COLD);
        active      = irq_mode ? irq_pending : comp_q;
        od_pull_low = active ^ act_high;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shut_q <= 1'b0;
            comp_q <= 1'b0;
            irq_q  <= IRQ_ARM_HOT;
        end else begin
            shut_q <= shutdown;
            irq_q  <= irq_nxt;
            if (irq_mode)      comp_q <= 1'b0;
            else if (hot_evt)  comp_q <= 1'b1;
            else if (cold_evt) comp_q <= 1'b0;
        end
    end

    // R6: hot event in comparator mode turns the alarm on
    a_r6_hot_sets: assert property (@(posedge clk) disable iff (rst)
        (!irq_mode && hot_evt) |=> comp_q);

    // R7: a read clears a pending interrupt
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_mode && reg_read && irq_pending) |=> !irq_pending);

    // R8: shutdown entry drops a pending interrupt
    a_r8_shutdown_irq: assert property (@(posedge clk) disable iff (rst)
        (irq_mode && shutdown && !shut_q && irq_pending) |=> !irq_pending);

    // R8: comparator state survives shutdown
    a_r8_shutdown_comp: assert property (@(posedge clk) disable iff (rst)
        (!irq_mode && shutdown && comp_q) |=> comp_q);
endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl #(
    parameter int TEMP_W = 9,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp_temp,
    input  logic [TEMP_W-1:0] thr_high,
    input  logic [TEMP_W-1:0] thr_low,
    input  logic [7:0]        cfg_reg,
    input  logic              reg_read,
    output logic              od_pull_low
);
    import thal_pkg::*;

    cfg_t cfg;
    cmp_t cmp;
    logic accept;
    logic hot_evt;
    logic cold_evt;

    assign cfg    = cfg_t'(cfg_reg);
    assign accept = smp_valid && !cfg.shutdown;

    thal_compare #(.TEMP_W(TEMP_W)) u_cmp (
        .temp   (smp_temp),
        .hi_thr (thr_high),
        .lo_thr (thr_low),
        .res    (cmp)
    );

    thal_fault_queue #(.CNT_W(CNT_W)) u_fq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cmp       (cmp),
        .depth_sel (cfg.depth_sel),
        .hot_evt   (hot_evt),
        .cold_evt  (cold_evt)
    );

    thal_alarm_out u_out (
        .clk         (clk),
        .rst         (rst),
        .hot_evt     (hot_evt),
        .cold_evt    (cold_evt),
        .reg_read    (reg_read),
        .irq_mode    (cfg.irq_mode),
        .act_high    (cfg.act_high),
        .shutdown    (cfg.shutdown),
        .od_pull_low (od_pull_low)
    );
endmodule

// File: tb/sim_thermal_alarm_ctrl.sv
`timescale 1ns/1ps
module sim_thermal_alarm_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [8:0] smp_temp = '0;
    logic [8:0] thr_high = 9'd50;
    logic [8:0] thr_low  = 9'h1EC; // -20
    logic [7:0] cfg_reg = 8'h00;
    logic       reg_read = 1'b0;
    logic       od_pull_low;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    thermal_alarm_ctrl u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .thr_high(thr_high), .thr_low(thr_low), .cfg_reg(cfg_reg),
        .reg_read(reg_read), .od_pull_low(od_pull_low)
    );

    localparam logic [8:0] HOT  = 9'd100;
    localparam logic [8:0] COLD = 9'h1CE; // -50
    localparam logic [8:0] MID  = 9'd0;

    task automatic chk(input logic exp, input string tag);
        n_chk++;
        if (od_pull_low !== exp) begin
            n_bad++;
            $display("FAIL %s: od_pull_low=%b expected=%b", tag, od_pull_low, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic [8:0] t);
        smp_temp  = t;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic rd();
        reg_read = 1'b1;
        @(negedge clk);
        reg_read = 1'b0;
    endtask

    task automatic setcfg(input logic [7:0] v);
        cfg_reg = v;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic exp_act;
        @(negedge clk);
        do_reset();
        chk(1'b0, "R1 reset state");

        // R2/R6 sweep of all sample codes, comparator, depth 1, active-low
        exp_act = 1'b0;
        for (int i = 0; i < 512; i++) begin
            logic [8:0] t;
            int ts;
            t  = 9'((i * 37 + 11) % 512);
            ts = (t >= 256) ? int'(t) - 512 : int'(t);
            if (ts > 50)       exp_act = 1'b1;
            else if (ts < -20) exp_act = 1'b0;
            send(t);
            chk(exp_act, "R2 R6 signed sweep");
        end
        // R2 equality boundaries
        send(HOT);  chk(1'b1, "R2 set");
        send(9'd50); chk(1'b1, "R2 equal high kept");
        send(9'h1EC); chk(1'b1, "R2 equal low not cold");
        send(9'h1EB); chk(1'b0, "R2 below low clears");
        send(9'd50); chk(1'b0, "R2 equal high not hot");

        // R3 sweep: every depth code, run lengths 1..7
        for (int q = 0; q < 4; q++) begin
            int d;
            d = (q == 0) ? 1 : (q == 1) ? 2 : (q == 2) ? 4 : 6;
            do_reset();
            setcfg(8'(q << 3));
            for (int k = 1; k <= 7; k++) begin
                send(HOT);
                chk(k >= d, "R3 depth run");
            end
        end

        // R4 run restarted by a mid sample, then by a cold sample
        do_reset();
        setcfg(8'h10); // depth 4
        send(HOT); send(HOT); send(HOT); send(MID);
        send(HOT); send(HOT); send(HOT);
        chk(1'b0, "R4 mid breaks run");
        send(HOT);
        chk(1'b1, "R4 fourth after restart");
        send(COLD); send(COLD); send(COLD); send(HOT); send(COLD);
        chk(1'b1, "R4 hot breaks cold run");
        send(COLD); send(COLD); send(COLD);
        chk(1'b0, "R4 cold run of four clears");

        // R5 samples ignored in shutdown
        do_reset();
        setcfg(8'h08); // depth 2
        send(HOT);
        setcfg(8'h09);
        send(HOT); send(MID); send(COLD);
        setcfg(8'h08);
        chk(1'b0, "R5 shutdown samples not counted");
        send(HOT);
        chk(1'b1, "R5 run not broken by ignored samples");

        // R7 interrupt cycle
        do_reset();
        setcfg(8'h02);
        chk(1'b0, "R7 idle");
        send(HOT);  chk(1'b1, "R7 hot event");
        send(COLD); chk(1'b1, "R7 held through cold");
        rd();       chk(1'b0, "R7 read clears hot");
        send(HOT);  chk(1'b0, "R7 hot ignored when armed cold");
        send(COLD); chk(1'b1, "R7 cold event");
        send(HOT);  chk(1'b1, "R7 cold held");
        rd();       chk(1'b0, "R7 read clears cold");
        send(COLD); chk(1'b0, "R7 cold ignored when armed hot");
        send(HOT);  chk(1'b1, "R7 rearmed hot");

        // R8 shutdown entry in interrupt mode
        setcfg(8'h03);
        chk(1'b0, "R8 shutdown clears interrupt");
        setcfg(8'h02);
        send(HOT);  chk(1'b0, "R8 armed cold after shutdown");
        send(COLD); chk(1'b1, "R8 cold after shutdown");

        // R8 comparator held through shutdown, R10 read ignored
        do_reset();
        setcfg(8'h00);
        send(HOT);
        setcfg(8'h01);
        chk(1'b1, "R8 comparator held in shutdown");
        rd();
        chk(1'b1, "R10 read ignored in shutdown comparator");
        setcfg(8'h00);
        rd();
        chk(1'b1, "R10 read ignored in comparator");

        // R9 active-high polarity
        do_reset();
        setcfg(8'h04);
        chk(1'b1, "R9 inactive releases low drive inverted");
        send(HOT);  chk(1'b0, "R9 active high not pulled");
        send(COLD); chk(1'b1, "R9 back to inactive");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule